// File: doc/BRIEF.md
# I2C Register-Access Target

This block is an I2C target. It lets an external bus master read and write a byte-wide internal register array. Every access goes through one address pointer that the block keeps between transfers. SCL and SDA are open-drain lines. The system clock oversamples both lines through a two-stage synchroniser, and the block detects START, repeated START and STOP from the synchronised levels. The block pulls SDA low through an output enable and never drives it high.

After a START, the block compares the upper seven bits of the select byte with its parameterised device address.

- **Write mode (R/W = 0):** the next byte loads the pointer. Each byte after that is written to the register file through a one-cycle strobe, and the pointer then steps forward.
- **Read mode (R/W = 1):** the block returns bytes starting at the current pointer. It moves on to the next byte for as long as the master acknowledges.

A random read is a write-mode select and an address byte, followed by a repeated START and a read-mode select. The pointer wraps from the last register back to zero. It keeps its value across STOP and is cleared only by reset.

Top module: `i2c_reg_target`

## Requirements
- R1: A select byte whose bits [7:1] equal DEV_ADDR and whose bit 0 (R/W) is 0 is acknowledged: SDA is held low for the 9th SCL pulse. The byte that follows is taken as the register address.
- R2: The address byte and every written data byte are acknowledged on their 9th SCL pulse. Each data byte appears once as `reg_we` high for one cycle, with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte.
- R3: Successive written data bytes go to successive addresses, so the pointer advances by one per byte. It wraps from 2**AW-1 to 0, and the same wrap applies to read bursts.
- R4: A matching select byte with R/W = 1 is acknowledged. The block then drives the register at the current pointer MSB first, with no address phase.
- R5: After a write-mode select, an address byte, a repeated START and a read-mode select, the first byte returned is the register at the newly written address.
- R6: While the master acknowledges each read byte (SDA low on the 9th pulse), the block returns the registers at successive addresses.
- R7: When the master answers a read byte with NACK, the block stops driving SDA and stays released until the next START or STOP. The pointer ends one past the last byte sent.
- R8: A select byte with a different device address is not acknowledged. Until the next START or STOP, the block then neither drives SDA nor writes any register, and it leaves the pointer unchanged.
- R9: After reset, `sda_oe` and `reg_we` are 0 and the pointer (`reg_addr`) is 0. `sda_oe` changes only while SCL is low, except when a START or STOP releases it.
- R10: The pointer keeps its value across a STOP, so a later current-address read continues from where the previous transfer left it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| reg_we | output | 1 | One-cycle write strobe to the register file |
| reg_addr | output | AW | Pointer; write address during `reg_we`, read address otherwise |
| reg_wdata | output | 8 | Byte to write |
| reg_rdata | input | 8 | Register file contents at `reg_addr` (combinational) |

## Verification
The bench builds the block with the default parameters: device address 0x2A, AW = 8 (256 registers) and two synchroniser stages. With AW = 8, a write burst and a read burst can both cross the 0xFF-to-0x00 wrap in a few bytes. The bench holds each SCL phase for 8 system clocks, which leaves room for the synchroniser and output register latency between an SCL fall and the next SDA change. A mismatched select address 0x18 checks that a wrong target leaves no trace on the strobe, the line or the pointer.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int BYTE_W = 8;

    // Top-level activity of the target.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // released, waiting for START
        ST_RX   = 2'd1,   // receiving a byte from the master
        ST_TX   = 2'd2    // shifting a register byte out
    } tgt_state_e;

    // Meaning of the byte being received.
    typedef enum logic [1:0] {
        RL_SEL  = 2'd0,   // device select byte
        RL_ADDR = 2'd1,   // register address byte
        RL_DATA = 2'd2    // register data byte
    } rx_role_e;

endpackage

// File: rtl/i2c_tgt_line_sync.sv
module i2c_tgt_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic ev_start,
    output logic ev_stop
);

    typedef struct packed {
        logic [STAGES-1:0] scl_pipe;
        logic [STAGES-1:0] sda_pipe;
        logic              scl_prev;
        logic              sda_prev;
    } sync_t;

    sync_t sync_d, sync_q;

    // Next-state logic: shift both lines in and keep one previous sample.
    always_comb begin
        sync_d          = sync_q;
        sync_d.scl_pipe = {sync_q.scl_pipe[STAGES-2:0], scl_i};
        sync_d.sda_pipe = {sync_q.sda_pipe[STAGES-2:0], sda_i};
        sync_d.scl_prev = sync_q.scl_pipe[STAGES-1];
        sync_d.sda_prev = sync_q.sda_pipe[STAGES-1];
    end

    // Reset to the idle (high) bus level.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    assign scl_s    = sync_q.scl_pipe[STAGES-1];
    assign sda_s    = sync_q.sda_pipe[STAGES-1];
    assign scl_rise = scl_s & ~sync_q.scl_prev;
    assign scl_fall = ~scl_s & sync_q.scl_prev;
    // START: SDA falls while SCL stays high. STOP: SDA rises while SCL stays high.
    assign ev_start = scl_s & sync_q.scl_prev & sync_q.sda_prev & ~sda_s;
    assign ev_stop  = scl_s & sync_q.scl_prev & ~sync_q.sda_prev & sda_s;

endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h2A,
    parameter int         AW       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              ev_start,
    input  logic              ev_stop,
    input  logic [BYTE_W-1:0] reg_rdata,
    output logic              sda_oe,
    output logic              reg_we,
    output logic [AW-1:0]     reg_addr,
    output logic [BYTE_W-1:0] reg_wdata
);

    // Bit-count values: 8 rising SCL edges complete a byte; the 9th is the ack slot.
    localparam logic [3:0] CNT_BYTE = 4'd8;
    localparam logic [3:0] CNT_ACK  = 4'd9;

    typedef struct packed {
        tgt_state_e        st;
        rx_role_e          role;
        logic [3:0]        cnt;
        logic [BYTE_W-1:0] shreg;
        logic [AW-1:0]     ptr;
        logic              oe;
        logic              rw;
        logic              mack;
        logic              we;
        logic [BYTE_W-1:0] wdata;
    } eng_t;

    eng_t eng_d, eng_q;

    always_comb begin
        eng_d    = eng_q;
        eng_d.we = 1'b0;
        if (ev_stop) begin
            eng_d.st = ST_IDLE;
            eng_d.oe = 1'b0;
        end else if (ev_start) begin
            eng_d.st   = ST_RX;
            eng_d.role = RL_SEL;
            eng_d.cnt  = 4'd0;
            eng_d.oe   = 1'b0;
        end else begin
            case (eng_q.st)
                ST_RX: begin
                    if (scl_rise && eng_q.cnt < CNT_ACK) begin
                        if (eng_q.cnt < CNT_BYTE)
                            eng_d.shreg = {eng_q.shreg[BYTE_W-2:0], sda_s};
                        eng_d.cnt = eng_q.cnt + 4'd1;
                    end else if (scl_fall && eng_q.cnt == CNT_BYTE) begin
                        // Byte complete: decide the acknowledge.
                        case (eng_q.role)
                            RL_SEL: begin
                                if (eng_q.shreg[7:1] == DEV_ADDR) begin
                                    eng_d.oe = 1'b1;
                                    eng_d.rw = eng_q.shreg[0];
                                end else begin
                                    eng_d.st = ST_IDLE;
                                end
                            end
                            RL_ADDR: begin
                                eng_d.ptr = eng_q.shreg[AW-1:0];
                                eng_d.oe  = 1'b1;
                            end
                            default: begin
                                eng_d.we    = 1'b1;
                                eng_d.wdata = eng_q.shreg;
                                eng_d.oe    = 1'b1;
                            end
                        endcase
                    end else if (scl_fall && eng_q.cnt == CNT_ACK) begin
                        // End of the acknowledge slot.
                        eng_d.oe  = 1'b0;
                        eng_d.cnt = 4'd0;
                        case (eng_q.role)
                            RL_SEL: begin
                                if (eng_q.rw) begin
                                    eng_d.st    = ST_TX;
                                    eng_d.shreg = reg_rdata;
                                    eng_d.oe    = ~reg_rdata[7];
                                end else begin
                                    eng_d.role = RL_ADDR;
                                end
                            end
                            RL_ADDR: eng_d.role = RL_DATA;
                            default: eng_d.ptr = eng_q.ptr + 1'b1;
                        endcase
                    end
                end
                ST_TX: begin
                    if (scl_rise && eng_q.cnt < CNT_ACK) begin
                        if (eng_q.cnt == CNT_BYTE) eng_d.mack = ~sda_s;
                        eng_d.cnt = eng_q.cnt + 4'd1;
                    end else if (scl_fall) begin
                        if (eng_q.cnt >= 4'd1 && eng_q.cnt <= 4'd7) begin
                            eng_d.shreg = {eng_q.shreg[BYTE_W-2:0], 1'b0};
                            eng_d.oe    = ~eng_q.shreg[6];
                        end else if (eng_q.cnt == CNT_BYTE) begin
                            // Release SDA for the master's answer; the byte counts as sent.
                            eng_d.oe  = 1'b0;
                            eng_d.ptr = eng_q.ptr + 1'b1;
                        end else if (eng_q.cnt == CNT_ACK) begin
                            if (eng_q.mack) begin
                                eng_d.cnt   = 4'd0;
                                eng_d.shreg = reg_rdata;
                                eng_d.oe    = ~reg_rdata[7];
                            end else begin
                                eng_d.st = ST_IDLE;
                            end
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q      <= '0;
            eng_q.st   <= ST_IDLE;
            eng_q.role <= RL_SEL;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign sda_oe    = eng_q.oe;
    assign reg_we    = eng_q.we;
    assign reg_addr  = eng_q.ptr;
    assign reg_wdata = eng_q.wdata;

    // R9: the SDA drive changes only while SCL is low, except on a START or STOP release.
    p_oe_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.oe != $past(eng_q.oe)) |-> (!$past(scl_s) || $past(ev_start) || $past(ev_stop)));

    // R8: an idle target neither drives the line nor writes.
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.st == ST_IDLE) |-> (!eng_q.oe && !eng_q.we));

    // R2: while receiving, SDA is pulled only in the acknowledge slot.
    p_rx_ack_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.st == ST_RX && eng_q.oe) |-> (eng_q.cnt >= CNT_BYTE));

    // R3: every write strobe lasts exactly one cycle.
    p_we_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        eng_q.we |=> !eng_q.we);

    // R10: a STOP leaves the pointer untouched.
    p_ptr_hold_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stop |=> (eng_q.ptr == $past(eng_q.ptr)));

    // R7: during the master's answer to a read byte the line is released.
    p_tx_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.st == ST_TX && eng_q.cnt == CNT_ACK) |-> !eng_q.oe);

endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h2A,
    parameter int         AW          = 8,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic              reg_we,
    output logic [AW-1:0]     reg_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    input  logic [BYTE_W-1:0] reg_rdata
);

    logic scl_s, sda_s, scl_rise, scl_fall, ev_start, ev_stop;

    i2c_tgt_line_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .ev_start (ev_start),
        .ev_stop  (ev_stop)
    );

    i2c_tgt_engine #(
        .DEV_ADDR (DEV_ADDR),
        .AW       (AW)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .ev_start  (ev_start),
        .ev_stop   (ev_stop),
        .reg_rdata (reg_rdata),
        .sda_oe    (sda_oe),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata)
    );

endmodule

// File: tb/tb_i2c_reg_target.sv
module tb_i2c_reg_target;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;             // system clocks per SCL phase
    localparam logic [7:0] SEL_W = 8'h54;      // 0x2A, write
    localparam logic [7:0] SEL_R = 8'h55;      // 0x2A, read

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe, reg_we;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    wire  sda_line = sda_m & ~sda_oe;

    logic [7:0] mem [256];      // register file seen by the block
    logic [7:0] ref_mem [256];  // expected contents, kept by the bench
    logic [15:0] exp_wr [$];
    int checks = 0;
    int errors = 0;
    int mptr = 0;
    bit done = 1'b0;
    logic prev_oe = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign reg_rdata = mem[reg_addr];

    i2c_reg_target dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_m),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Per-clock comparison against the model's expected write stream and the line rule.
    always @(negedge clk) begin
        if (rst_n) begin
            if (reg_we) begin
                if (exp_wr.size() == 0) begin
                    chk(1'b0, "R8 unexpected write", {reg_addr, reg_wdata}, 0);
                end else begin
                    logic [15:0] e;
                    e = exp_wr.pop_front();
                    chk({reg_addr, reg_wdata} == e, "R2 write strobe", {reg_addr, reg_wdata}, e);
                end
                mem[reg_addr] = reg_wdata;
            end
            if (sda_oe !== prev_oe)
                chk(!scl_m, "R9 sda_oe change with SCL low", scl_m, 0);
            prev_oe = sda_oe;
        end
    end

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wclk(HALF);
        scl_m = 1'b1; wclk(HALF);
        sda_m = 1'b0; wclk(HALF);
        scl_m = 1'b0; wclk(HALF);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wclk(HALF);
        scl_m = 1'b1; wclk(HALF);
        sda_m = 1'b1; wclk(HALF);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; wclk(HALF);
        scl_m = 1'b1; wclk(HALF);
        scl_m = 1'b0;
    endtask

    task automatic recv_bit(output logic v);
        sda_m = 1'b1; wclk(HALF);
        scl_m = 1'b1; wclk(HALF/2);
        v = sda_line; wclk(HALF/2);
        scl_m = 1'b0;
    endtask

    task automatic write_byte(input logic [7:0] b, output bit acked);
        logic v;
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        recv_bit(v);
        acked = ~v;
    endtask

    task automatic read_byte(input bit mack, output logic [7:0] d);
        logic v;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(v);
            d[i] = v;
        end
        send_bit(~mack);
    endtask

    // Data write through the model: expected strobe and pointer step.
    task automatic write_data(input logic [7:0] b);
        bit a;
        exp_wr.push_back({mptr[7:0], b});
        ref_mem[mptr] = b;
        write_byte(b, a);
        chk(a, "R2 data ack", a, 1);
        mptr = (mptr + 1) % 256;
    endtask

    task automatic read_expect(input bit mack, input string req);
        logic [7:0] d;
        read_byte(mack, d);
        chk(d == ref_mem[mptr], req, d, ref_mem[mptr]);
        mptr = (mptr + 1) % 256;
    endtask

    task automatic finish_sim();
        chk(exp_wr.size() == 0, "R2 all writes seen", exp_wr.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R9 watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bit a;
        logic v;
        bit all_high;
        for (int i = 0; i < 256; i++) begin
            mem[i]     = 8'((i * 37 + 11) % 256);
            ref_mem[i] = 8'((i * 37 + 11) % 256);
        end
        wclk(5);
        rst_n = 1'b1;
        wclk(2);
        // R9: reset state
        chk(sda_oe == 1'b0, "R9 reset sda_oe", sda_oe, 0);
        chk(reg_we == 1'b0, "R9 reset reg_we", reg_we, 0);
        chk(reg_addr == 8'h00, "R9 reset pointer", reg_addr, 0);

        // R1/R2: addressed burst write of two bytes
        bus_start();
        write_byte(SEL_W, a);  chk(a, "R1 write select ack", a, 1);
        write_byte(8'h10, a);  chk(a, "R2 address ack", a, 1);
        mptr = 8'h10;
        write_data(8'hA5);
        write_data(8'h3C);
        bus_stop();
        chk(reg_addr == 8'h12, "R3 pointer after burst", reg_addr, 8'h12);

        // R3: write burst across the wrap
        bus_start();
        write_byte(SEL_W, a);  chk(a, "R1 write select ack", a, 1);
        write_byte(8'hFE, a);  chk(a, "R2 address ack", a, 1);
        mptr = 8'hFE;
        write_data(8'h11);
        write_data(8'h22);
        write_data(8'h33);
        bus_stop();
        chk(reg_addr == 8'h01, "R3 pointer wrap", reg_addr, 8'h01);

        // R4/R10: current-address read after STOP
        bus_start();
        write_byte(SEL_R, a);  chk(a, "R4 read select ack", a, 1);
        read_expect(1'b0, "R4 R10 current-address data");
        bus_stop();
        chk(reg_addr == 8'h02, "R7 pointer past last byte", reg_addr, 8'h02);

        // R5/R6/R7: random read with repeated START, then NACK
        bus_start();
        write_byte(SEL_W, a);  chk(a, "R1 write select ack", a, 1);
        write_byte(8'h10, a);  chk(a, "R2 address ack", a, 1);
        mptr = 8'h10;
        bus_start();
        write_byte(SEL_R, a);  chk(a, "R5 read select ack", a, 1);
        read_expect(1'b1, "R5 random read first byte");
        read_expect(1'b0, "R6 sequential read byte");
        all_high = 1'b1;
        for (int i = 0; i < 9; i++) begin
            recv_bit(v);
            if (v !== 1'b1) all_high = 1'b0;
        end
        chk(all_high, "R7 line released after NACK", all_high, 1);
        bus_stop();
        chk(reg_addr == 8'h12, "R7 pointer after NACK", reg_addr, 8'h12);

        // R6/R3: read burst across the wrap
        bus_start();
        write_byte(SEL_W, a);  chk(a, "R1 write select ack", a, 1);
        write_byte(8'hFF, a);  chk(a, "R2 address ack", a, 1);
        mptr = 8'hFF;
        bus_start();
        write_byte(SEL_R, a);  chk(a, "R4 read select ack", a, 1);
        read_expect(1'b1, "R6 burst byte at 0xFF");
        read_expect(1'b1, "R3 R6 burst byte after wrap");
        read_expect(1'b0, "R6 burst last byte");
        bus_stop();

        // R8: mismatched device address, write then read mode
        bus_start();
        write_byte(8'h30, a);  chk(!a, "R8 no ack on mismatch", a, 0);
        write_byte(8'h07, a);  chk(!a, "R8 ignored address byte", a, 0);
        write_byte(8'h99, a);  chk(!a, "R8 ignored data byte", a, 0);
        bus_stop();
        chk(reg_addr == 8'h02, "R8 pointer unchanged", reg_addr, 8'h02);
        bus_start();
        write_byte(8'h57, a);  chk(!a, "R8 no ack on read mismatch", a, 0);
        all_high = 1'b1;
        for (int i = 0; i < 9; i++) begin
            recv_bit(v);
            if (v !== 1'b1) all_high = 1'b0;
        end
        chk(all_high, "R8 no drive after mismatch", all_high, 1);
        bus_stop();

        // R10: pointer still persists after several STOPs
        bus_start();
        write_byte(SEL_R, a);  chk(a, "R4 read select ack", a, 1);
        read_expect(1'b0, "R10 pointer persisted");
        bus_stop();

        wclk(20);
        done = 1'b1;
        finish_sim();
    end

endmodule